// File: doc/BRIEF.md
# Synchronous Memory-Bus Loopback Target

This block lets a host memory controller confirm that its address and data wiring to a programmable-logic device is sound. To the host, the device looks like a synchronous static memory. Address and data use separate lines. The host runs the bus clock without pause, and each access is a single 32-bit beat.

Inside the block there is one probe register.

- **Writes.** A write to word address zero loads the data word into the register. A write to any other word address ignores the data and loads the word address itself, zero-extended. This lets the host check every address line.
- **Reads.** Every read returns the register after a fixed number of bus clocks. A read never changes the register, so the dummy read that the host issues ahead of each real read is harmless.
- **Busy indication.** An active-low busy pin drops when an access starts. It rises again a short, fixed time after chip select is released, so the host can poll it. The busy pin never stretches the read latency.

The data bus is split into an input word, an output word and an output enable, which feed the pad drivers outside the block. Control pins are plain active-low levels sampled on the rising clock edge. There is no back-pressure: each access completes in the cycles stated below.

Top module: `psram_probe_target`

## Requirements
- R1: After reset, the probe register reads back as zero, `wait_n` is 1 and `data_oe` is 0.
- R2: An access starts on a rising edge where both `cs_n` and `adv_n` are 0. With `we_n` at 0 it is a write; with `we_n` at 1 it is a read.
- R3: A write whose address is zero loads `data_i`, sampled at the same edge, into the probe register.
- R4: A write whose address is non-zero loads the address, zero-extended to DATA_W bits, into the probe register, and `data_i` has no effect. The highest address 0x3FFFFF therefore reads back as 0x003FFFFF.
- R5: For a read started at edge E0, `data_oe` stays 0 after E0 through edge E0+RD_LAT-2. After edge E0+RD_LAT-1, `data_oe` is 1 and `data_o` holds the probe register, so the host samples valid data at edge E0+RD_LAT. This holds whatever the state of `wait_n`.
- R6: `data_oe` is 1 only while `cs_n` is 0, `oe_n` is 0 and the read latency has elapsed. At all other times it is 0 and `data_o` is zero.
- R7: A read leaves the probe register unchanged. Back-to-back reads (a dummy read followed by the real one) return the same value.
- R8: `wait_n` falls in the cycle after any access starts. It stays 0 while `cs_n` is 0. It returns to 1 after WAIT_RELEASE consecutive rising edges with `cs_n` at 1.
- R9: A write strobe with `adv_n` at 1, or with `cs_n` at 1, leaves the probe register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address valid, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (22) | Word address |
| data_i | input | DATA_W (32) | Write data from the bus |
| data_o | output | DATA_W (32) | Read data to the pad drivers |
| data_oe | output | 1 | Drive enable for the data pads |
| wait_n | output | 1 | Busy indication, active low, idles high |

## Verification
The bench builds the block with its default parameters: a 22-bit address, a 32-bit data word, a read latency of 3 and a release delay of 2. With these values the all-ones word address and the zero-extension into the top ten data bits can be reached directly.

Because the latency and release delay are small, the bench can check the driving cycle and the busy window of every read and write exactly.

Random writes are split between address zero and non-zero addresses, so both loading paths alternate many times. Each write is followed by the same dummy-then-real read pair that the host uses.

// File: rtl/psram_probe_pkg.sv
package psram_probe_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/probe_access_decode.sv
module probe_access_decode
  import psram_probe_pkg::*;
(
  input  logic      cs_n,
  input  logic      adv_n,
  input  logic      we_n,
  output acc_kind_e kind
);
  // An access begins only when select and address-valid coincide.
  always_comb begin
    if (!cs_n && !adv_n) kind = we_n ? ACC_READ : ACC_WRITE;
    else                 kind = ACC_IDLE;
  end
endmodule

// File: rtl/probe_test_reg.sv
module probe_test_reg #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] probe_q
);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] addr_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign addr_ext = {{PAD_W{1'b0}}, addr};
    end else begin : g_trunc
      assign addr_ext = addr[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      probe_q <= '0;
    end else if (wr_stb) begin
      probe_q <= (addr == '0) ? wdata : addr_ext;
    end
  end
endmodule

// File: rtl/probe_read_timer.sv
module probe_read_timer #(
  parameter int RD_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_start,
  input  logic wr_start,
  output logic ready
);
  localparam int CNT_W = $clog2(RD_LAT + 1);
  localparam logic [CNT_W-1:0] LAT_V = CNT_W'(RD_LAT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cs_n || wr_start) begin
      cnt_q <= '0;
    end else if (rd_start) begin
      cnt_q <= CNT_W'(1);
    end else if (cnt_q != '0 && cnt_q != LAT_V) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign ready = (cnt_q == LAT_V);
endmodule

// File: rtl/probe_wait_gen.sv
module probe_wait_gen #(
  parameter int WAIT_RELEASE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic acc_start,
  output logic wait_n
);
  localparam int REL_W = $clog2(WAIT_RELEASE + 1);
  localparam logic [REL_W-1:0] LAST_V = REL_W'(WAIT_RELEASE - 1);

  logic [REL_W-1:0] rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_n <= 1'b1;
      rel_q  <= '0;
    end else if (acc_start) begin
      wait_n <= 1'b0;
      rel_q  <= '0;
    end else if (!wait_n) begin
      if (!cs_n) begin
        rel_q <= '0;
      end else if (rel_q == LAST_V) begin
        wait_n <= 1'b1;
        rel_q  <= '0;
      end else begin
        rel_q <= rel_q + REL_W'(1);
      end
    end
  end
endmodule

// File: rtl/psram_probe_target.sv
module psram_probe_target
  import psram_probe_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int DATA_W       = 32,
  parameter int RD_LAT       = 3,
  parameter int WAIT_RELEASE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              adv_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic              wait_n
);
  acc_kind_e         kind;
  logic              wr_start;
  logic              rd_start;
  logic              rd_ready;
  logic [DATA_W-1:0] test_q;

  probe_access_decode u_decode (
    .cs_n  (cs_n),
    .adv_n (adv_n),
    .we_n  (we_n),
    .kind  (kind)
  );

  assign wr_start = (kind == ACC_WRITE);
  assign rd_start = (kind == ACC_READ);

  probe_test_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_start),
    .addr    (addr),
    .wdata   (data_i),
    .probe_q (test_q)
  );

  probe_read_timer #(.RD_LAT(RD_LAT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_start (rd_start),
    .wr_start (wr_start),
    .ready    (rd_ready)
  );

  probe_wait_gen #(.WAIT_RELEASE(WAIT_RELEASE)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .acc_start (wr_start | rd_start),
    .wait_n    (wait_n)
  );

  assign data_oe = rd_ready & ~cs_n & ~oe_n;
  assign data_o  = data_oe ? test_q : '0;
endmodule

// File: rtl/psram_probe_checker.sv
module psram_probe_checker #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              adv_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe,
  input logic              wait_n,
  input logic [DATA_W-1:0] test_q
);
  logic start;
  assign start = !cs_n && !adv_n;

  AST_OE_NEEDS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!cs_n && !oe_n)); // R6

  AST_OE_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && we_n) |=> !data_oe); // R5

  AST_OE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (data_o == test_q)); // R5

  AST_WAIT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !wait_n); // R8

  AST_WAIT_HELD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_n && !cs_n) |=> !wait_n); // R8

  AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !we_n && addr == '0) |=> (test_q == $past(data_i))); // R3

  AST_WRITE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !we_n && addr != '0) |=> (test_q == DATA_W'($past(addr)))); // R4

  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && we_n) |=> $stable(test_q)); // R7

  AST_NO_START_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(test_q)); // R9
endmodule

bind psram_probe_target psram_probe_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n),
  .adv_n   (adv_n),
  .we_n    (we_n),
  .oe_n    (oe_n),
  .addr    (addr),
  .data_i  (data_i),
  .data_o  (data_o),
  .data_oe (data_oe),
  .wait_n  (wait_n),
  .test_q  (test_q)
);

// File: tb/test_psram_probe_target.sv
module test_psram_probe_target;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 22;
  localparam int DW = 32;
  localparam int LAT = 3;
  localparam int REL = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, adv_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe;
  logic          wait_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psram_probe_target i_psram_probe_target (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .data_i(data_i), .data_o(data_o),
    .data_oe(data_oe), .wait_n(wait_n)
  );

  function automatic logic [DW-1:0] expect_after_write(input logic [AW-1:0] a,
                                                       input logic [DW-1:0] d);
    return (a == '0) ? d : {{(DW-AW){1'b0}}, a};
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit check_wait);
    @(negedge clk);
    cs_n = 0; adv_n = 0; we_n = 0; addr = a; data_i = d;
    @(negedge clk);
    if (check_wait) check("R8 busy after start", {31'd0, wait_n}, 32'd0);
    cs_n = 1; adv_n = 1; we_n = 1; data_i = ~d;
    for (int i = 0; i < REL; i++) begin
      if (check_wait) check("R8 busy before release", {31'd0, wait_n}, 32'd0);
      @(negedge clk);
    end
    if (check_wait) check("R8 released", {31'd0, wait_n}, 32'd1);
    model = expect_after_write(a, d);
  endtask

  task automatic host_read(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    cs_n = 0; adv_n = 0; we_n = 1; oe_n = 0; addr = a;
    for (int i = 1; i < LAT; i++) begin
      @(negedge clk);
      adv_n = 1;
      check("R5 no drive before latency", {31'd0, data_oe}, 32'd0);
    end
    @(negedge clk);
    check("R5 drive after latency", {31'd0, data_oe}, 32'd1);
    check(req, data_o, model);
    cs_n = 1; oe_n = 1;
    #1;
    check("R6 release on deselect", {31'd0, data_oe}, 32'd0);
    check("R6 zero when idle", data_o, 32'd0);
    repeat (REL + 1) @(negedge clk);
  endtask

  task automatic host_read_pair(input logic [AW-1:0] a, input string req);
    host_read(a, req);
    host_read(a, "R7 repeat read stable");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    check("R1 wait idle at reset", {31'd0, wait_n}, 32'd1);
    check("R1 no drive at reset", {31'd0, data_oe}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    host_read_pair('0, "R1 register zero after reset");

    host_write('0, 32'hDEADBEEF, 1);
    host_read_pair('0, "R3 data stored");
    host_write(22'h3FFFFF, 32'h12345678, 1);
    host_read_pair('0, "R4 top address zero-extended");
    host_write(22'h000001, 32'hFFFFFFFF, 0);
    host_read_pair(22'h000001, "R4 lowest non-zero address");
    host_write('0, 32'hFFFFFFFF, 0);
    host_read_pair('0, "R3 all ones");
    host_write('0, 32'h0, 0);
    host_read_pair('0, "R3 all zeros");

    // R9: strobe without address-valid, then with chip deselected.
    host_write('0, 32'hA5A5A5A5, 0);
    @(negedge clk);
    cs_n = 0; adv_n = 1; we_n = 0; addr = 22'h00ABCD; data_i = 32'h11111111;
    @(negedge clk);
    cs_n = 1; adv_n = 0; we_n = 0; addr = 22'h001234; data_i = 32'h22222222;
    @(negedge clk);
    adv_n = 1; we_n = 1;
    repeat (REL + 1) @(negedge clk);
    host_read_pair('0, "R9 ignored strobes");

    // R2: write and read distinguished by we_n at the same address.
    host_write(22'h000040, 32'h0, 0);
    host_read(22'h000040, "R2 read does not write");

    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      d = $urandom();
      a = ($urandom_range(0, 2) == 0) ? '0 : AW'($urandom());
      host_write(a, d, (n % 16) == 0);
      host_read_pair(AW'($urandom()), (a == '0) ? "R3 random data" : "R4 random address");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule